// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides, for every identifier handed to it by a CAN receiver, whether the frame is kept, which of two receive queues takes it, and which filter match index goes with it. It holds no configuration of its own. Each of the fourteen filter banks is described by two 32-bit value words plus four single-bit settings: width (one 32-bit comparison or a pair of 16-bit halves), style (exact list or value/care-mask), queue assignment and an active flag. These inputs come from a register block elsewhere and are expected to stay fixed while frames are being filtered.

Depending on width and style, a bank splits into one, two or four filters. Filters are numbered per queue, in ascending bank order, with inactive filters still taking their numbers. A frame that hits any active queue-0 filter goes to queue 0. Only when nothing in queue 0 hits is queue 1 considered. Inside the chosen queue, a fixed priority of width, then style, then index picks one winner.

A frame is presented with a one-cycle strobe. One clock later a registered result-valid pulse appears, together with the accept flag, the queue and the index.

Top module: `can_accept_filter`

## Requirements
- R1: `res_valid` is high in the cycle after each clock in which `frm_valid` is high, and is low in every other cycle.
- R2: After reset, while `res_valid` is low, and for a dropped frame, `res_accept`, `res_queue` and `res_index` are all 0.
- R3: Comparison keys are built from the frame fields, most significant bit first. The 32-bit key is {std[10:0], ext[17:0], ide, rtr, 0}. The 16-bit key is {std[10:0], rtr, ide, ext[17:15]}. In 32-bit mask mode (wide=1, list=0) the bank is one filter: word 2 is the care mask and word 1 is the value. Only key bits whose mask bit is 1 must be equal.
- R4: In 32-bit list mode (wide=1, list=1) the bank forms two exact-match filters on the 32-bit key: slot 0 uses word 1 and slot 1 uses word 2.
- R5: In 16-bit mask mode (wide=0, list=0) the bank forms two filters on the 16-bit key. Slot 0 uses word 1 and slot 1 uses word 2. Within each word, bits 31:16 are the care mask and bits 15:0 are the value.
- R6: In 16-bit list mode (wide=0, list=1) the bank forms four exact-match filters on the 16-bit key. The slots are, in order, word1[15:0], word1[31:16], word2[15:0] and word2[31:16].
- R7: The match index is the filter's number within its queue. Numbering starts at 0 and counts filters bank by bank in ascending order, active or not, and slot by slot within a bank.
- R8: A frame that hits any active queue-0 filter is reported with `res_queue`=0, whatever queue-1 filters also hit. Queue 1 is reported only when no queue-0 filter hits.
- R9: When several filters in the chosen queue hit, 32-bit filters win over 16-bit filters. At equal width, list filters win over mask filters. At equal width and style, the lower index wins.
- R10: Filters of banks whose active bit is 0 never hit. When no bank is active, every frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | One-cycle strobe: identifier fields are valid |
| id_std | input | 11 | Standard identifier part |
| id_ext | input | 18 | Extended identifier part |
| id_ide | input | 1 | Extended-format flag |
| id_rtr | input | 1 | Remote-request flag |
| cfg_word1 | input | NBANK*32 | Value word 1 of each bank, bank b at [b*32+:32] |
| cfg_word2 | input | NBANK*32 | Value word 2 of each bank, bank b at [b*32+:32] |
| cfg_wide | input | NBANK | 1: 32-bit filters, 0: 16-bit filters |
| cfg_list | input | NBANK | 1: exact list, 0: value/mask |
| cfg_queue | input | NBANK | Queue the bank feeds (0 or 1) |
| cfg_active | input | NBANK | Bank takes part in matching |
| res_valid | output | 1 | Decision valid pulse |
| res_accept | output | 1 | Frame accepted |
| res_queue | output | 1 | Destination queue |
| res_index | output | $clog2(4*NBANK+1) | Match index within the queue |

## Verification
Each of the four bank layouts gets identifiers that hit each slot separately, plus near misses that differ only in a masked-in bit, the remote flag, the format flag or the top extended bits. These show that each slot compares the right word half against the correctly aligned key. A layout of mixed, partly inactive banks split over both queues gives indices that only come out right if inactive and other-queue filters are counted properly. Frames that hit filters in both queues, and frames that hit filters of every width and style at once, separate queue precedence from in-queue priority. Removing the high-priority banks must expose the lower tiers in order.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int NBANK = 14,
  parameter int IDXW  = $clog2(4*NBANK+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  input  logic [10:0]        id_std,
  input  logic [17:0]        id_ext,
  input  logic               id_ide,
  input  logic               id_rtr,
  input  logic [NBANK*32-1:0] cfg_word1,
  input  logic [NBANK*32-1:0] cfg_word2,
  input  logic [NBANK-1:0]   cfg_wide,
  input  logic [NBANK-1:0]   cfg_list,
  input  logic [NBANK-1:0]   cfg_queue,
  input  logic [NBANK-1:0]   cfg_active,
  output logic               res_valid,
  output logic               res_accept,
  output logic               res_queue,
  output logic [IDXW-1:0]    res_index
);

  logic [31:0] key32;
  logic [15:0] key16;
  assign key32 = {id_std, id_ext, id_ide, id_rtr, 1'b0};
  assign key16 = {id_std, id_rtr, id_ide, id_ext[17:15]};

  logic [4*NBANK-1:0] hit_all;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [31:0] w1, w2;
    logic [3:0]  h;
    assign w1 = cfg_word1[g*32 +: 32];
    assign w2 = cfg_word2[g*32 +: 32];
    always_comb begin
      h = 4'b0;
      case ({cfg_wide[g], cfg_list[g]})
        2'b10: h[0] = ((key32 ^ w1) & w2) == 32'h0;
        2'b11: begin
          h[0] = key32 == w1;
          h[1] = key32 == w2;
        end
        2'b00: begin
          h[0] = ((key16 ^ w1[15:0]) & w1[31:16]) == 16'h0;
          h[1] = ((key16 ^ w2[15:0]) & w2[31:16]) == 16'h0;
        end
        default: begin
          h[0] = key16 == w1[15:0];
          h[1] = key16 == w1[31:16];
          h[2] = key16 == w2[15:0];
          h[3] = key16 == w2[31:16];
        end
      endcase
    end
    assign hit_all[g*4 +: 4] = cfg_active[g] ? h : 4'b0;
  end

  function automatic logic [2:0] slot_count(input logic wide, input logic list);
    return wide ? (list ? 3'd2 : 3'd1) : (list ? 3'd4 : 3'd2);
  endfunction

  function automatic logic [1:0] first_slot(input logic [3:0] h);
    if (h[0]) return 2'd0;
    if (h[1]) return 2'd1;
    if (h[2]) return 2'd2;
    return 2'd3;
  endfunction

  logic [IDXW-1:0] base0, base1, best0, best1;
  logic [1:0]      rank0, rank1, rank_b;
  logic            found0, found1;
  logic [3:0]      hb;

  always_comb begin
    base0 = '0; base1 = '0; best0 = '0; best1 = '0;
    rank0 = '0; rank1 = '0; found0 = 1'b0; found1 = 1'b0;
    hb = '0; rank_b = '0;
    for (int b = 0; b < NBANK; b++) begin
      hb     = hit_all[b*4 +: 4];
      rank_b = {cfg_wide[b], cfg_list[b]};
      if (cfg_queue[b]) begin
        if (|hb && (!found1 || rank_b > rank1)) begin
          found1 = 1'b1;
          rank1  = rank_b;
          best1  = base1 + IDXW'(first_slot(hb));
        end
        base1 = base1 + IDXW'(slot_count(cfg_wide[b], cfg_list[b]));
      end else begin
        if (|hb && (!found0 || rank_b > rank0)) begin
          found0 = 1'b1;
          rank0  = rank_b;
          best0  = base0 + IDXW'(first_slot(hb));
        end
        base0 = base0 + IDXW'(slot_count(cfg_wide[b], cfg_list[b]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_queue  <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid <= frm_valid;
      if (frm_valid && (found0 || found1)) begin
        res_accept <= 1'b1;
        res_queue  <= !found0;
        res_index  <= found0 ? best0 : best1;
      end else begin
        res_accept <= 1'b0;
        res_queue  <= 1'b0;
        res_index  <= '0;
      end
    end
  end

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NBANK = 14,
  parameter int IDXW  = $clog2(4*NBANK+1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frm_valid,
  input logic [NBANK-1:0] cfg_queue,
  input logic [NBANK-1:0] cfg_active,
  input logic            res_valid,
  input logic            res_accept,
  input logic            res_queue,
  input logic [IDXW-1:0] res_index
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid);

  assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_accept && !res_queue && res_index == '0));

  assert_drop_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> (!res_queue && res_index == '0));

  assert_none_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_active == '0) |=> !res_accept);

  assert_q1_needs_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (cfg_active & cfg_queue) == '0) |=> !(res_accept && res_queue));

  assert_index_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> (int'(res_index) < 4*NBANK));

endmodule

bind can_accept_filter can_accept_filter_chk #(.NBANK(NBANK), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
  .cfg_queue(cfg_queue), .cfg_active(cfg_active),
  .res_valid(res_valid), .res_accept(res_accept),
  .res_queue(res_queue), .res_index(res_index)
);

// File: tb/can_accept_filter_bench.sv
`timescale 1ns/1ps
module can_accept_filter_bench;
  localparam int NB = 14;
  localparam int IW = $clog2(4*NB+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic [10:0] id_std = '0;
  logic [17:0] id_ext = '0;
  logic id_ide = 1'b0, id_rtr = 1'b0;
  logic [NB*32-1:0] w1 = '0, w2 = '0;
  logic [NB-1:0] wide = '0, list = '0, que = '0, act = '0;
  logic res_valid, res_accept, res_queue;
  logic [IW-1:0] res_index;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_accept_filter #(.NBANK(NB)) u_can_accept_filter (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
    .id_std(id_std), .id_ext(id_ext), .id_ide(id_ide), .id_rtr(id_rtr),
    .cfg_word1(w1), .cfg_word2(w2), .cfg_wide(wide), .cfg_list(list),
    .cfg_queue(que), .cfg_active(act),
    .res_valid(res_valid), .res_accept(res_accept),
    .res_queue(res_queue), .res_index(res_index)
  );

  function automatic logic [31:0] k32(input logic [10:0] s, input logic [17:0] e, input logic ide, input logic rtr);
    return {s, e, ide, rtr, 1'b0};
  endfunction

  function automatic logic [15:0] k16(input logic [10:0] s, input logic [17:0] e, input logic ide, input logic rtr);
    return {s, rtr, ide, e[17:15]};
  endfunction

  task automatic check(input bit ok, input string tag, input string act_s, input string exp_s);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %s, expected %s", tag, act_s, exp_s);
    end
  endtask

  task automatic clear_cfg();
    w1 = '0; w2 = '0; wide = '1; list = '0; que = '0; act = '0;
  endtask

  task automatic set_bank(input int b, input logic [31:0] a, input logic [31:0] m,
                          input logic wd, input logic ls, input logic q, input logic ac);
    w1[b*32 +: 32] = a; w2[b*32 +: 32] = m;
    wide[b] = wd; list[b] = ls; que[b] = q; act[b] = ac;
  endtask

  task automatic send(input logic [10:0] s, input logic [17:0] e, input logic ide, input logic rtr,
                      input logic ea, input logic eq, input int ei, input string tag);
    logic [IW-1:0] xi;
    xi = ea ? IW'(ei) : '0;
    @(negedge clk);
    frm_valid = 1'b1; id_std = s; id_ext = e; id_ide = ide; id_rtr = rtr;
    @(negedge clk);
    frm_valid = 1'b0;
    check(res_valid === 1'b1 && res_accept === ea && res_queue === (ea & eq) && res_index === xi, tag,
          $sformatf("v=%b acc=%b q=%b idx=%0d", res_valid, res_accept, res_queue, res_index),
          $sformatf("v=1 acc=%b q=%b idx=%0d", ea, ea & eq, xi));
    @(negedge clk);
    check(res_valid === 1'b0 && res_accept === 1'b0, "R1 pulse",
          $sformatf("v=%b acc=%b", res_valid, res_accept), "v=0 acc=0");
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(res_valid === 1'b0 && res_accept === 1'b0 && res_queue === 1'b0 && res_index === '0, "R2 reset",
          $sformatf("v=%b acc=%b q=%b idx=%0d", res_valid, res_accept, res_queue, res_index), "all 0");
  endtask

  task automatic t_inactive();
    clear_cfg();
    send(11'h123, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R10 nothing active");
    set_bank(0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(11'h123, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R10 inactive accept-all bank");
  endtask

  task automatic t_mask32();
    clear_cfg();
    set_bank(0, k32(11'h123, 18'h0, 1'b0, 1'b0), 32'hFFE0_0000, 1'b1, 1'b0, 1'b0, 1'b1);
    send(11'h123, 18'h5, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R3 std match, rest ignored");
    send(11'h124, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R3 std mismatch");
    set_bank(0, 32'h0000_0004, 32'h0000_0004, 1'b1, 1'b0, 1'b0, 1'b1);
    send(11'h000, 18'h7, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R3 ide bit position");
    send(11'h000, 18'h7, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R3 ide mismatch");
  endtask

  task automatic t_list32();
    clear_cfg();
    set_bank(2, k32(11'h010, 18'h0, 1'b0, 1'b0), k32(11'h7FF, 18'h3FFFF, 1'b1, 1'b0), 1'b1, 1'b1, 1'b0, 1'b1);
    send(11'h010, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2, "R4 word1 slot");
    send(11'h7FF, 18'h3FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 3, "R4 word2 slot");
    send(11'h011, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R4 no match");
    send(11'h010, 18'h0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R4 rtr differs");
  endtask

  task automatic t_mask16();
    clear_cfg();
    set_bank(0, {16'hFFE0, k16(11'h055, 18'h0, 1'b0, 1'b0)},
                {16'hFFFF, k16(11'h066, 18'h38000, 1'b0, 1'b1)}, 1'b0, 1'b0, 1'b0, 1'b1);
    send(11'h055, 18'h3, 1'b1, 1'b1, 1'b1, 1'b0, 0, "R5 slot0 masked");
    send(11'h066, 18'h38000, 1'b0, 1'b1, 1'b1, 1'b0, 1, "R5 slot1 full mask");
    send(11'h066, 18'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R5 ext top bits differ");
    send(11'h066, 18'h38000, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R5 rtr differs");
  endtask

  task automatic t_list16();
    clear_cfg();
    set_bank(0, {k16(11'h101, 18'h0, 1'b0, 1'b1), k16(11'h100, 18'h0, 1'b0, 1'b0)},
                {k16(11'h103, 18'h0, 1'b0, 1'b0), k16(11'h102, 18'h08000, 1'b1, 1'b0)},
             1'b0, 1'b1, 1'b0, 1'b1);
    send(11'h100, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R6 word1 low");
    send(11'h101, 18'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1, "R6 word1 high");
    send(11'h102, 18'h08000, 1'b1, 1'b0, 1'b1, 1'b0, 2, "R6 word2 low");
    send(11'h103, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3, "R6 word2 high");
    send(11'h104, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R6 miss");
  endtask

  task automatic t_numbering();
    clear_cfg();
    set_bank(0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    set_bank(1, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0);
    set_bank(2, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    set_bank(3, k32(11'h300, 18'h1234, 1'b1, 1'b0), 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
    set_bank(4, 32'hFFFF_FFFF, k32(11'h0F0, 18'h0, 1'b0, 1'b0), 1'b1, 1'b1, 1'b0, 1'b1);
    send(11'h300, 18'h1234, 1'b1, 1'b0, 1'b1, 1'b1, 2, "R7 queue1 index past inactive");
    send(11'h0F0, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 7, "R7 queue0 index past inactive");
  endtask

  task automatic t_queue();
    clear_cfg();
    set_bank(0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    set_bank(5, k32(11'h5A5, 18'h0, 1'b0, 1'b0), 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1);
    send(11'h5A5, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4, "R8 both queues hit, queue0 wins");
    send(11'h001, 18'h0, 1'b0, 1'b0, 1'b1, 1'b1, 0, "R8 only queue1 hits");
  endtask

  task automatic t_priority();
    clear_cfg();
    set_bank(0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    set_bank(1, {16'hFFFF, k16(11'h2AA, 18'h0, 1'b0, 1'b0)}, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1);
    set_bank(2, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    set_bank(3, 32'hFFFF_FFFF, k32(11'h2AA, 18'h0, 1'b0, 1'b0), 1'b1, 1'b1, 1'b0, 1'b1);
    send(11'h2AA, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8, "R9 wide list beats all");
    send(11'h111, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 6, "R9 wide mask beats narrow");
    act[2] = 1'b0; act[3] = 1'b0;
    send(11'h2AA, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2, "R9 narrow list beats narrow mask");
    send(11'h111, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R9 lower index at same tier");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inactive();
    t_mask32();
    t_list32();
    t_mask16();
    t_list16();
    t_numbering();
    t_queue();
    t_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule